// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Recency Stamps

This block caches virtual-to-physical page mappings in a small, fully associative table. Every slot holds a virtual page base, a physical page base, its own page-size exponent and four attribute flags: global, user, writable and uncacheable. Because the size is stored per slot, one table can hold pages of mixed sizes. A lookup compares the address with every slot at once. On a hit it returns the physical address one cycle later, formed from the slot's physical base and the low address bits below that slot's exponent.

Recency is kept as a stamp per slot, taken from one free-running sequence counter. An insert that misses fills the lowest free slot. When no slot is free, it replaces the slot with the smallest stamp. An insert whose page is already mapped is dropped, so the existing mapping stays. Three maintenance commands remove entries: wipe everything, wipe only the non-global entries, or drop the single entry covering one address.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no slot is valid, `rspValid` is low, and every lookup misses.
- R2: A lookup presented in one cycle reports on `rspValid`/`rspHit`/`rspPa`/`rspFlags` in the next cycle. On a hit, `rspPa` is the slot's physical base ORed with the address bits below the slot's exponent. `rspFlags` is {global, user, writable, uncacheable}, with bit 3 as global and bit 0 as uncacheable.
- R3: A slot matches an address only when both agree in every bit at or above that slot's exponent.
- R4: An insert that misses takes a free slot while one exists, so up to ENTRIES distinct pages stay resident together.
- R5: An insert whose virtual address falls inside an already valid page changes nothing: no slot is written or evicted, and the old physical base and flags are kept.
- R6: An insert that misses into a full table replaces the valid slot with the smallest stamp. On equal stamps, the lowest index is replaced.
- R7: A new entry takes the next value of the sequence counter as its stamp. A hitting lookup with `lookupRefresh` set also gives the hit slot the next value. A lookup without refresh leaves every stamp unchanged.
- R8: `flushAll` invalidates every slot.
- R9: `flushLocal` invalidates every slot whose global flag is clear and keeps the global ones.
- R10: `dropPage` invalidates only the slot that covers `dropVa`. It leaves all stamps untouched, and the freed slot is reused before any eviction.
- R11: A maintenance command in the same cycle as an insert wins. The insert is discarded, and a refresh in that cycle is skipped too.
- R12: The counter starts at 1. When a stamp would be issued while the counter is at its maximum, all stamps are cleared to 0, the target slot receives 1 and the counter continues from 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request |
| lookupVa | input | ADDR_W | Lookup virtual address |
| lookupRefresh | input | 1 | On a hit, give the slot a fresh stamp |
| rspValid | output | 1 | Lookup result valid |
| rspHit | output | 1 | Lookup hit |
| rspPa | output | ADDR_W | Translated physical address |
| rspFlags | output | 4 | {global, user, writable, uncacheable} of hit slot |
| insValid | input | 1 | Insert request |
| insVa | input | ADDR_W | Virtual address of new mapping |
| insPa | input | ADDR_W | Physical address of new mapping |
| insExp | input | EXP_W | Page-size exponent of new mapping |
| insFlags | input | 4 | Flags of new mapping, same order as rspFlags |
| flushAll | input | 1 | Invalidate all slots |
| flushLocal | input | 1 | Invalidate non-global slots |
| dropPage | input | 1 | Invalidate the slot covering dropVa |
| dropVa | input | ADDR_W | Address for dropPage |

## Verification
A wrong stamp cannot be seen at once. It shows up only at the next eviction into a full table, when the wrong page disappears and a later lookup of it misses. The bench therefore follows each eviction with lookups of every page that could have been chosen. A faulty match mask or valid bit shows in the very next lookup response, one cycle after the request. A small counter width is used in the bench, so the wrap rule is reached and its effect on eviction order is observed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic global;
    logic user;
    logic writable;
    logic uncacheable;
  } tlbFlags_t;

  // Strobes from control to storage, one per cycle
  typedef struct packed {
    logic wrEn;       // write a new mapping at wrIdx
    logic stampEn;    // load stampVal into stampIdx
    logic renorm;     // clear every stamp first (counter wrap)
    logic killAll;    // invalidate every slot
    logic killLocal;  // invalidate non-global slots
    logic killPage;   // invalidate the slot covering dropVa
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int EXP_W   = 5,
  parameter int SEQ_W   = 32,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  stampIdx,
  input  logic [SEQ_W-1:0]  stampVal,
  input  logic [ADDR_W-1:0] wrVa,
  input  logic [ADDR_W-1:0] wrPa,
  input  logic [EXP_W-1:0]  wrExp,
  input  tlbFlags_t         wrFlags,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupVa,
  input  logic [ADDR_W-1:0] insVa,
  input  logic [ADDR_W-1:0] dropVa,
  output logic              lookupHit,
  output logic [IDX_W-1:0]  lookupIdx,
  output logic              insDup,
  output logic              freeAny,
  output logic [IDX_W-1:0]  freeIdx,
  output logic [IDX_W-1:0]  victimIdx,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspPa,
  output tlbFlags_t         rspFlags
);

  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [ENTRIES-1:0]             validR;
  logic [ENTRIES-1:0][ADDR_W-1:0] vbaseR;
  logic [ENTRIES-1:0][ADDR_W-1:0] pbaseR;
  logic [ENTRIES-1:0][EXP_W-1:0]  expR;
  tlbFlags_t [ENTRIES-1:0]        flagsR;
  logic [ENTRIES-1:0][SEQ_W-1:0]  stampR;

  logic [ENTRIES-1:0][ADDR_W-1:0] lowMask;
  logic [ENTRIES-1:0]             lkMatch, insMatch, dropMatch, globalVec, killVec;
  logic                           dropHit;
  logic [IDX_W-1:0]               dropIdx;
  logic [ADDR_W-1:0]              wrMask;

  // Per-slot compare against the three address sources
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic isNewest;
    assign lowMask[i]   = ~(ALL_ONES << expR[i]);
    assign lkMatch[i]   = validR[i] && (((lookupVa ^ vbaseR[i]) & ~lowMask[i]) == '0);
    assign insMatch[i]  = validR[i] && (((insVa    ^ vbaseR[i]) & ~lowMask[i]) == '0);
    assign dropMatch[i] = validR[i] && (((dropVa   ^ vbaseR[i]) & ~lowMask[i]) == '0);
    assign globalVec[i] = flagsR[i].global;

    always_comb begin
      isNewest = 1'b1;
      for (int j = 0; j < ENTRIES; j++)
        if (j != i && stampR[j] >= stampR[i]) isNewest = 1'b0;
    end

    // A freshly issued stamp is strictly the largest in the table
    AST_STAMP_NEWEST: assert property (@(posedge clk) disable iff (!rstN)
      strobe.stampEn && stampIdx == IDX_W'(i) |=> isNewest); // R12
  end

  // Lowest index wins every search
  always_comb begin
    lookupHit = 1'b0; lookupIdx = '0;
    dropHit   = 1'b0; dropIdx   = '0;
    freeAny   = 1'b0; freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i])   begin lookupHit = 1'b1; lookupIdx = IDX_W'(i); end
      if (dropMatch[i]) begin dropHit   = 1'b1; dropIdx   = IDX_W'(i); end
      if (!validR[i])   begin freeAny   = 1'b1; freeIdx   = IDX_W'(i); end
    end
  end

  assign insDup = |insMatch;

  // Smallest stamp; strict compare keeps the lowest index on ties
  always_comb begin
    victimIdx = '0;
    for (int i = 1; i < ENTRIES; i++)
      if (stampR[i] < stampR[victimIdx]) victimIdx = IDX_W'(i);
  end

  always_comb begin
    killVec = '0;
    if (strobe.killAll) killVec = '1;
    else begin
      if (strobe.killLocal) killVec = ~globalVec;
      if (strobe.killPage && dropHit) killVec[dropIdx] = 1'b1;
    end
  end

  assign wrMask = ~(ALL_ONES << wrExp);

  always_ff @(posedge clk) begin
    if (!rstN) validR <= '0;
    else begin
      validR <= validR & ~killVec;
      if (strobe.wrEn) validR[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      vbaseR[wrIdx] <= wrVa & ~wrMask;
      pbaseR[wrIdx] <= wrPa & ~wrMask;
      expR[wrIdx]   <= wrExp;
      flagsR[wrIdx] <= wrFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stampR <= '0;
    else begin
      if (strobe.renorm) stampR <= '0;
      if (strobe.stampEn) stampR[stampIdx] <= stampVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= lookupValid;
      rspHit   <= lookupValid && lookupHit;
    end
    rspPa    <= pbaseR[lookupIdx] | (lookupVa & lowMask[lookupIdx]);
    rspFlags <= flagsR[lookupIdx];
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killAll |=> validR == '0); // R8
  AST_LOCAL_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.killLocal && !strobe.killAll |=> (validR & ~globalVec) == '0); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> validR[$past(wrIdx)]); // R4
  AST_STAMPS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stampEn && !strobe.renorm |=> $stable(stampR)); // R7

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int SEQ_W = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupRefresh,
  input  logic             lookupHit,
  input  logic [IDX_W-1:0] lookupIdx,
  input  logic             insValid,
  input  logic             insDup,
  input  logic             freeAny,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic [IDX_W-1:0] victimIdx,
  input  logic             flushAll,
  input  logic             flushLocal,
  input  logic             dropPage,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] stampIdx,
  output logic [SEQ_W-1:0] stampVal
);

  localparam logic [SEQ_W-1:0] SEQ_MAX = {SEQ_W{1'b1}};

  logic [SEQ_W-1:0] seqR;
  logic             maint, refreshGo;

  assign maint = flushAll || flushLocal || dropPage;
  assign wrIdx = freeAny ? freeIdx : victimIdx;

  always_comb begin
    strobe           = '0;
    strobe.killAll   = flushAll;
    strobe.killLocal = flushLocal;
    strobe.killPage  = dropPage;
    strobe.wrEn      = insValid && !maint && !insDup;
    refreshGo        = lookupValid && lookupRefresh && lookupHit && !maint && !strobe.wrEn;
    strobe.stampEn   = strobe.wrEn || refreshGo;
    strobe.renorm    = strobe.stampEn && (seqR == SEQ_MAX);
    stampIdx         = strobe.wrEn ? wrIdx : lookupIdx;
    stampVal         = strobe.renorm ? SEQ_W'(1) : seqR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqR <= SEQ_W'(1);
    else if (strobe.stampEn) seqR <= strobe.renorm ? SEQ_W'(2) : seqR + 1'b1;
  end

  AST_SEQ_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    seqR != '0); // R12
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.renorm |=> seqR == SEQ_W'(2)); // R12

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int EXP_W   = 5,
  parameter int SEQ_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupVa,
  input  logic              lookupRefresh,
  output logic              rspValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspPa,
  output logic [3:0]        rspFlags,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insVa,
  input  logic [ADDR_W-1:0] insPa,
  input  logic [EXP_W-1:0]  insExp,
  input  logic [3:0]        insFlags,
  input  logic              flushAll,
  input  logic              flushLocal,
  input  logic              dropPage,
  input  logic [ADDR_W-1:0] dropVa
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  if (ENTRIES < 1) begin : g_bad_size
    $error("tlb_assoc: ENTRIES must be at least 1");
  end

  tlbStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx, stampIdx, lookupIdx, freeIdx, victimIdx;
  logic [SEQ_W-1:0] stampVal;
  logic             lookupHit, insDup, freeAny;
  tlbFlags_t        rspFlagsS;

  tlb_ctrl #(.SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rstN, .lookupValid, .lookupRefresh, .lookupHit, .lookupIdx,
    .insValid, .insDup, .freeAny, .freeIdx, .victimIdx,
    .flushAll, .flushLocal, .dropPage,
    .strobe, .wrIdx, .stampIdx, .stampVal
  );

  tlb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .EXP_W(EXP_W),
              .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_store (
    .clk, .rstN, .strobe, .wrIdx, .stampIdx, .stampVal,
    .wrVa(insVa), .wrPa(insPa), .wrExp(insExp), .wrFlags(tlbFlags_t'(insFlags)),
    .lookupValid, .lookupVa, .insVa, .dropVa,
    .lookupHit, .lookupIdx, .insDup, .freeAny, .freeIdx, .victimIdx,
    .rspValid, .rspHit, .rspPa, .rspFlags(rspFlagsS)
  );

  assign rspFlags = rspFlagsS;

endmodule

// File: tb/tlb_assoc_tb.sv
`timescale 1ns/1ps
module tlb_assoc_tb;
  localparam int ENT = 4, AW = 32, EW = 5, SW = 4;
  localparam int NOPS = 49;
  // kind: 0 lookup, 1 refresh lookup, 2 insert, 3 flushAll, 4 flushLocal,
  //       5 dropPage, 6 insert together with flushAll
  // row = {kind[3], va[32], pa[32], exp[5], flags[4], req[4]}
  localparam logic [79:0] OPS [NOPS] = '{
    {3'd0, 32'h0000_1000, 32'h0, 5'd0, 4'h0, 4'd1},          // R1 miss when empty
    {3'd2, 32'h0000_1000, 32'h8000_1000, 5'd12, 4'h2, 4'd4}, // R4
    {3'd2, 32'h0002_0000, 32'h9000_0000, 5'd16, 4'h8, 4'd4}, // R4
    {3'd2, 32'h0000_3000, 32'hA000_3000, 5'd12, 4'h5, 4'd4}, // R4
    {3'd2, 32'h0000_4400, 32'hB000_4400, 5'd8,  4'h1, 4'd4}, // R4
    {3'd0, 32'h0000_1ABC, 32'h0, 5'd0, 4'h0, 4'd2},          // R2
    {3'd0, 32'h0002_1234, 32'h0, 5'd0, 4'h0, 4'd3},          // R3
    {3'd0, 32'h0003_1234, 32'h0, 5'd0, 4'h0, 4'd3},          // R3
    {3'd0, 32'h0000_44FF, 32'h0, 5'd0, 4'h0, 4'd3},          // R3
    {3'd0, 32'h0000_4500, 32'h0, 5'd0, 4'h0, 4'd3},          // R3
    {3'd0, 32'h0000_3FFC, 32'h0, 5'd0, 4'h0, 4'd2},          // R2
    {3'd2, 32'h0000_1FF0, 32'hCCCC_0000, 5'd12, 4'h0, 4'd5}, // R5 duplicate
    {3'd0, 32'h0000_1004, 32'h0, 5'd0, 4'h0, 4'd5},          // R5
    {3'd1, 32'h0000_1000, 32'h0, 5'd0, 4'h0, 4'd7},          // R7
    {3'd2, 32'h0000_5000, 32'hD000_5000, 5'd12, 4'h0, 4'd6}, // R6
    {3'd0, 32'h0002_0000, 32'h0, 5'd0, 4'h0, 4'd6},          // R6
    {3'd0, 32'h0000_1000, 32'h0, 5'd0, 4'h0, 4'd7},          // R7
    {3'd2, 32'h0000_6000, 32'hE000_6000, 5'd12, 4'h2, 4'd6}, // R6
    {3'd0, 32'h0000_3000, 32'h0, 5'd0, 4'h0, 4'd6},          // R6
    {3'd5, 32'h0000_5123, 32'h0, 5'd0, 4'h0, 4'd10},         // R10
    {3'd0, 32'h0000_5000, 32'h0, 5'd0, 4'h0, 4'd10},         // R10
    {3'd2, 32'h0000_7000, 32'hF000_7000, 5'd12, 4'h4, 4'd10},// R10
    {3'd0, 32'h0000_4400, 32'h0, 5'd0, 4'h0, 4'd10},         // R10
    {3'd2, 32'h0000_8000, 32'h1200_8000, 5'd12, 4'h0, 4'd6}, // R6
    {3'd0, 32'h0000_4400, 32'h0, 5'd0, 4'h0, 4'd6},          // R6
    {3'd1, 32'h0000_1000, 32'h0, 5'd0, 4'h0, 4'd12},         // R12
    {3'd1, 32'h0000_6000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd1, 32'h0000_7000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd1, 32'h0000_8000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd1, 32'h0000_1000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd1, 32'h0000_6000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd1, 32'h0000_7000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd2, 32'h0000_9000, 32'h2000_9000, 5'd12, 4'h0, 4'd12},// R12 eviction after wrap
    {3'd0, 32'h0000_1000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd0, 32'h0000_6000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd0, 32'h0000_7000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd0, 32'h0000_8000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd0, 32'h0000_9000, 32'h0, 5'd0, 4'h0, 4'd12},
    {3'd2, 32'h0000_A000, 32'h3000_A000, 5'd12, 4'h8, 4'd9}, // R9 global page
    {3'd4, 32'h0, 32'h0, 5'd0, 4'h0, 4'd9},                  // R9
    {3'd0, 32'h0000_A000, 32'h0, 5'd0, 4'h0, 4'd9},
    {3'd0, 32'h0000_7000, 32'h0, 5'd0, 4'h0, 4'd9},
    {3'd0, 32'h0000_9000, 32'h0, 5'd0, 4'h0, 4'd9},
    {3'd6, 32'h0000_B000, 32'h4000_B000, 5'd12, 4'h0, 4'd11},// R11
    {3'd0, 32'h0000_B000, 32'h0, 5'd0, 4'h0, 4'd11},         // R11
    {3'd0, 32'h0000_A000, 32'h0, 5'd0, 4'h0, 4'd8},          // R8
    {3'd2, 32'h0000_C000, 32'h5000_C000, 5'd12, 4'h3, 4'd8}, // R8
    {3'd0, 32'h0000_C777, 32'h0, 5'd0, 4'h0, 4'd8},          // R8
    {3'd0, 32'h1234_5678, 32'h0, 5'd0, 4'h0, 4'd3}           // R3
  };

  logic clk = 0, rstN;
  logic lookupValid, lookupRefresh, rspValid, rspHit;
  logic [AW-1:0] lookupVa, rspPa, insVa, insPa, dropVa;
  logic [3:0] rspFlags, insFlags;
  logic [EW-1:0] insExp;
  logic insValid, flushAll, flushLocal, dropPage;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_assoc #(.ENTRIES(ENT), .ADDR_W(AW), .EXP_W(EW), .SEQ_W(SW)) u_dut (.*);

  // Reference model built from the requirements
  logic          mValid [ENT];
  logic [AW-1:0] mVb [ENT], mPb [ENT];
  logic [EW-1:0] mEx [ENT];
  logic [3:0]    mFl [ENT];
  int unsigned   mSt [ENT];
  int unsigned   mSeq;

  function automatic logic [AW-1:0] lowOf(logic [EW-1:0] e);
    return ~({AW{1'b1}} << e);
  endfunction

  function automatic int mFind(logic [AW-1:0] va);
    for (int i = 0; i < ENT; i++)
      if (mValid[i] && (((va ^ mVb[i]) & ~lowOf(mEx[i])) == '0)) return i;
    return -1;
  endfunction

  task automatic mStamp(int idx);
    if (mSeq == (1 << SW) - 1) begin
      for (int i = 0; i < ENT; i++) mSt[i] = 0;
      mSt[idx] = 1; mSeq = 2;
    end else begin
      mSt[idx] = mSeq; mSeq++;
    end
  endtask

  task automatic check(bit ok, int req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    lookupValid = 0; lookupRefresh = 0; lookupVa = '0;
    insValid = 0; insVa = '0; insPa = '0; insExp = '0; insFlags = '0;
    flushAll = 0; flushLocal = 0; dropPage = 0; dropVa = '0;
  endtask

  task automatic runOp(logic [79:0] row);
    logic [2:0] kind; logic [AW-1:0] va, pa; logic [EW-1:0] ex; logic [3:0] fl;
    int req, hitIdx, tgt; bit isLk, maint, ins;
    logic [AW-1:0] expPa; logic [3:0] expFl;
    {kind, va, pa, ex, fl} = row[79:4];
    req = int'(row[3:0]);
    isLk  = (kind == 0 || kind == 1);
    maint = (kind >= 3);
    ins   = (kind == 2 || kind == 6);
    idleInputs();
    if (isLk) begin lookupValid = 1; lookupVa = va; lookupRefresh = (kind == 1); end
    if (ins) begin insValid = 1; insVa = va; insPa = pa; insExp = ex; insFlags = fl; end
    if (kind == 3 || kind == 6) flushAll = 1;
    if (kind == 4) flushLocal = 1;
    if (kind == 5) begin dropPage = 1; dropVa = va; end
    hitIdx = isLk ? mFind(va) : -1;
    expPa = '0; expFl = '0;
    if (hitIdx >= 0) begin
      expPa = mPb[hitIdx] | (va & lowOf(mEx[hitIdx]));
      expFl = mFl[hitIdx];
    end
    if (kind == 3 || kind == 6) for (int i = 0; i < ENT; i++) mValid[i] = 0;
    if (kind == 4) for (int i = 0; i < ENT; i++) if (!mFl[i][3]) mValid[i] = 0;
    if (kind == 5) begin tgt = mFind(va); if (tgt >= 0) mValid[tgt] = 0; end
    if (ins && !maint && mFind(va) < 0) begin
      tgt = -1;
      for (int i = ENT - 1; i >= 0; i--) if (!mValid[i]) tgt = i;
      if (tgt < 0) begin
        tgt = 0;
        for (int i = 1; i < ENT; i++) if (mSt[i] < mSt[tgt]) tgt = i;
      end
      mValid[tgt] = 1; mVb[tgt] = va & ~lowOf(ex); mPb[tgt] = pa & ~lowOf(ex);
      mEx[tgt] = ex; mFl[tgt] = fl;
      mStamp(tgt);
    end
    if (kind == 1 && hitIdx >= 0) mStamp(hitIdx);
    @(posedge clk); @(negedge clk);
    idleInputs();
    if (isLk) begin
      check(rspValid == 1'b1, req, "rspValid", AW'(rspValid), 1);
      check(rspHit == (hitIdx >= 0), req, "rspHit", AW'(rspHit), AW'(hitIdx >= 0));
      if (hitIdx >= 0) begin
        check(rspPa == expPa, req, "rspPa", rspPa, expPa);
        check(rspFlags == expFl, req, "rspFlags", AW'(rspFlags), AW'(expFl));
      end
    end
  endtask

  initial begin
    idleInputs();
    rstN = 0;
    for (int i = 0; i < ENT; i++) begin mValid[i] = 0; mSt[i] = 0; end
    mSeq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(rspValid == 1'b0, 1, "rspValid after reset", AW'(rspValid), 0); // R1
    for (int n = 0; n < NOPS; n++) runOp(OPS[n]);
    @(negedge clk);
    check(rspValid == 1'b0, 2, "rspValid idle", AW'(rspValid), 0); // R2
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule